// File: doc/BRIEF.md
# Prefix-Length Computing Route Array

This block is an array of IPv4 route entries that can be searched in parallel. Each entry stores a 32-bit route address, a prefix length and a valid bit. On a search, every entry computes how many leading bits of the key agree with its stored address. The count starts at the most significant bit and is capped at that entry's own prefix length. The block reports the capped count and a candidate flag for every entry, one clock after the search strobe.

Every entry reports a length, not just a hit/miss bit, so routes can be written into any slot in any order. A downstream selector picks the longest candidate. That selector is not part of this block, and neither is the next-hop lookup. Inside each entry the key is examined as four 8-bit groups, most significant group first. Each group produces a thermometer code of its leading agreeing bits. A group's code counts only when every more significant group agreed in full.

Top module: `pfx_len_cam`

## Requirements
- R1: A search strobe in cycle t makes `res_valid` high in cycle t+1, with that search's results on `res_hit` and `res_len`. `res_valid` is low in every cycle that does not follow a strobe.
- R2: For a valid entry, its 7-bit field of `res_len` (entry i at bits [7i+6:7i]) gives the number of consecutive equal bits between the key and the stored address. Counting starts at bit 31 and goes downward, and the result never exceeds the entry's prefix length.
- R3: `res_hit[i]` is 1 exactly when entry i is valid and its reported length equals its stored prefix length.
- R4: A valid entry with prefix length 0 is a candidate for every key and reports length 0.
- R5: An entry that is not valid reports `res_hit` 0 and length 0, whatever its stored address.
- R6: A write at a clock edge is seen by searches strobed in the following cycle. A search strobed in the same cycle as the write sees the entry's earlier contents.
- R7: A written prefix length greater than 32 is stored as 32.
- R8: After reset every entry is not valid, and `res_valid`, `res_hit` and `res_len` are all zero.
- R9: Between searches, `res_hit` and `res_len` keep the values of the last search.
- R10: Several entries may be candidates for the same key, and each entry's result does not depend on the slot it was written to or the order of writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 3 | Entry slot to write |
| wr_addr | input | 32 | Route address to store |
| wr_plen | input | 6 | Prefix length to store (clamped to 32) |
| wr_valid | input | 1 | Valid bit to store |
| srch_vld | input | 1 | Search strobe |
| srch_key | input | 32 | Search key |
| res_valid | output | 1 | Result of a search is present this cycle |
| res_hit | output | 8 | Per-entry candidate flag |
| res_len | output | 56 | Per-entry capped match length, 7 bits each |

## Verification
A write and a search can fall in the same cycle, and they can target the same slot. The bench provokes this by writing a valid route into a slot that was not valid, while it strobes a key that the new route would match. That search must still report the slot as not matching. A second search of the same key on the next strobe must then report the full prefix length and a hit. In the other direction, a slot is invalidated and then searched on the following strobe, and the result must drop to zero.

// File: rtl/pfx_cam_pkg.sv
package pfx_cam_pkg;
  // Default geometry of the route array
  localparam int unsigned KEY_W_DEF   = 32;
  localparam int unsigned GRP_W_DEF   = 8;
  localparam int unsigned LEN_W_DEF   = 7;
  localparam int unsigned ENTRIES_DEF = 8;
  localparam int unsigned PL_W_DEF    = $clog2(KEY_W_DEF + 1);
endpackage

// File: rtl/pfx_entry_store.sv
module pfx_entry_store
  import pfx_cam_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = ENTRIES_DEF,
  parameter int unsigned KEY_W       = KEY_W_DEF,
  parameter int unsigned PL_W        = $clog2(KEY_W + 1),
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [KEY_W-1:0]                  wr_addr,
  input  logic [PL_W-1:0]                   wr_plen,
  input  logic                              wr_valid,
  output logic [NUM_ENTRIES-1:0]            ent_vld,
  output logic [NUM_ENTRIES-1:0][KEY_W-1:0] ent_addr,
  output logic [NUM_ENTRIES-1:0][PL_W-1:0]  ent_plen
);
  localparam logic [PL_W-1:0] PL_MAX = PL_W'(KEY_W);

  logic [PL_W-1:0] plen_clamped;

  always_comb begin
    plen_clamped = (wr_plen > PL_MAX) ? PL_MAX : wr_plen;
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic            sel;
    logic            vld_d,  vld_q;
    logic [KEY_W-1:0] addr_d, addr_q;
    logic [PL_W-1:0]  plen_d, plen_q;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(i));
      vld_d  = sel ? wr_valid     : vld_q;
      addr_d = sel ? wr_addr      : addr_q;
      plen_d = sel ? plen_clamped : plen_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        plen_q <= '0;
      end else begin
        vld_q  <= vld_d;
        addr_q <= addr_d;
        plen_q <= plen_d;
      end
    end

    assign ent_vld[i]  = vld_q;
    assign ent_addr[i] = addr_q;
    assign ent_plen[i] = plen_q;
  end
endmodule

// File: rtl/pfx_group_therm.sv
module pfx_group_therm
  import pfx_cam_pkg::*;
#(
  parameter int unsigned GRP_W = GRP_W_DEF
) (
  input  logic [GRP_W-1:0] agree,  // MSB is the first bit examined
  output logic [GRP_W-1:0] therm   // therm[k]: first k+1 bits all agree
);
  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < GRP_W; k++) begin
      run      = run & agree[GRP_W-1-k];
      therm[k] = run;
    end
  end
endmodule

// File: rtl/pfx_entry_len.sv
module pfx_entry_len
  import pfx_cam_pkg::*;
#(
  parameter int unsigned KEY_W = KEY_W_DEF,
  parameter int unsigned GRP_W = GRP_W_DEF,
  parameter int unsigned PL_W  = $clog2(KEY_W + 1),
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] addr,
  input  logic [PL_W-1:0]  plen,
  input  logic             vld,
  output logic [LEN_W-1:0] len,
  output logic             hit
);
  localparam int unsigned NUM_GRP = KEY_W / GRP_W;

  logic [KEY_W-1:0]                  pmask;
  logic [KEY_W-1:0]                  agree;
  logic [NUM_GRP-1:0][GRP_W-1:0]     therm;
  logic [LEN_W-1:0]                  sum;

  // Leading-ones mask of the stored prefix length
  always_comb begin
    for (int i = 0; i < KEY_W; i++) begin
      pmask[KEY_W-1-i] = (PL_W'(i) < plen);
    end
    agree = ~(key ^ addr) & pmask;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pfx_group_therm #(.GRP_W(GRP_W)) u_therm (
      .agree (agree[KEY_W-1-g*GRP_W -: GRP_W]),
      .therm (therm[g])
    );
  end

  // A group's count is added only when all higher groups agreed fully
  always_comb begin
    logic             full;
    logic [LEN_W-1:0] cnt;
    full = 1'b1;
    sum  = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      cnt = '0;
      for (int k = 0; k < GRP_W; k++) begin
        cnt = cnt + LEN_W'(therm[g][k]);
      end
      if (full) sum = sum + cnt;
      full = full & therm[g][GRP_W-1];
    end
  end

  always_comb begin
    len = vld ? sum : '0;
    hit = vld && (sum == LEN_W'(plen));
  end
endmodule

// File: rtl/pfx_len_cam.sv
module pfx_len_cam
  import pfx_cam_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = ENTRIES_DEF,
  parameter int unsigned KEY_W       = KEY_W_DEF,
  parameter int unsigned GRP_W       = GRP_W_DEF,
  parameter int unsigned LEN_W       = LEN_W_DEF,
  parameter int unsigned PL_W        = $clog2(KEY_W + 1),
  parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [KEY_W-1:0]             wr_addr,
  input  logic [PL_W-1:0]              wr_plen,
  input  logic                         wr_valid,
  input  logic                         srch_vld,
  input  logic [KEY_W-1:0]             srch_key,
  output logic                         res_valid,
  output logic [NUM_ENTRIES-1:0]       res_hit,
  output logic [NUM_ENTRIES*LEN_W-1:0] res_len
);
  logic [NUM_ENTRIES-1:0]            ent_vld;
  logic [NUM_ENTRIES-1:0][KEY_W-1:0] ent_addr;
  logic [NUM_ENTRIES-1:0][PL_W-1:0]  ent_plen;
  logic [NUM_ENTRIES-1:0]            hit_w;
  logic [NUM_ENTRIES*LEN_W-1:0]      len_w;

  logic                              rv_d, rv_q;
  logic [NUM_ENTRIES-1:0]            hit_d, hit_q;
  logic [NUM_ENTRIES*LEN_W-1:0]      len_d, len_q;

  pfx_entry_store #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .KEY_W       (KEY_W),
    .PL_W        (PL_W),
    .IDX_W       (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_addr  (wr_addr),
    .wr_plen  (wr_plen),
    .wr_valid (wr_valid),
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .ent_plen (ent_plen)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    pfx_entry_len #(
      .KEY_W (KEY_W),
      .GRP_W (GRP_W),
      .PL_W  (PL_W),
      .LEN_W (LEN_W)
    ) u_len (
      .key  (srch_key),
      .addr (ent_addr[i]),
      .plen (ent_plen[i]),
      .vld  (ent_vld[i]),
      .len  (len_w[i*LEN_W +: LEN_W]),
      .hit  (hit_w[i])
    );
  end

  // Next-state: capture only on a search strobe
  always_comb begin
    rv_d  = srch_vld;
    hit_d = srch_vld ? hit_w : hit_q;
    len_d = srch_vld ? len_w : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      hit_q <= '0;
      len_q <= '0;
    end else begin
      rv_q  <= rv_d;
      hit_q <= hit_d;
      len_q <= len_d;
    end
  end

  assign res_valid = rv_q;
  assign res_hit   = hit_q;
  assign res_len   = len_q;
endmodule

// File: rtl/pfx_len_cam_chk.sv
module pfx_len_cam_chk #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned KEY_W       = 32,
  parameter int unsigned LEN_W       = 7,
  parameter int unsigned IDX_W       = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [IDX_W-1:0]             wr_idx,
  input logic                         wr_valid,
  input logic                         srch_vld,
  input logic                         res_valid,
  input logic [NUM_ENTRIES-1:0]       res_hit,
  input logic [NUM_ENTRIES*LEN_W-1:0] res_len
);
  p_strobe_to_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    srch_vld |=> res_valid);

  p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_vld |=> !res_valid);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_vld |=> ($stable(res_hit) && $stable(res_len)));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent_chk
    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_len[i*LEN_W +: LEN_W] <= LEN_W'(KEY_W)));

    p_invalid_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IDX_W'(i)) && !wr_valid) ##1 srch_vld
        |=> (!res_hit[i] && (res_len[i*LEN_W +: LEN_W] == '0)));
  end
endmodule

bind pfx_len_cam pfx_len_cam_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .KEY_W       (KEY_W),
  .LEN_W       (LEN_W),
  .IDX_W       (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_valid  (wr_valid),
  .srch_vld  (srch_vld),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_len   (res_len)
);

// File: tb/test_pfx_len_cam.sv
module test_pfx_len_cam;
  localparam int N   = 8;
  localparam int LW  = 7;
  localparam int NV  = 6;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_idx;
  logic [31:0]   wr_addr;
  logic [5:0]    wr_plen;
  logic          wr_valid;
  logic          srch_vld;
  logic [31:0]   srch_key;
  logic          res_valid;
  logic [N-1:0]  res_hit;
  logic [N*LW-1:0] res_len;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench-side record of what was written
  logic [31:0] sh_addr [N];
  int          sh_plen [N];
  logic        sh_vld  [N];

  // {key, expected candidate mask}
  localparam logic [39:0] VEC [NV] = '{
    {32'h0A010203, 8'h0F},
    {32'hC0A80144, 8'h98},
    {32'hC0A80100, 8'hA8},
    {32'h0B000000, 8'h08},
    {32'hFFFFFFFF, 8'h88},
    {32'h0A01FF00, 8'h0B}
  };

  pfx_len_cam i_pfx_len_cam (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_addr (wr_addr),
    .wr_plen (wr_plen), .wr_valid (wr_valid),
    .srch_vld (srch_vld), .srch_key (srch_key),
    .res_valid (res_valid), .res_hit (res_hit), .res_len (res_len)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int model_len(logic [31:0] key, int e);
    int c;
    int cap;
    if (!sh_vld[e]) return 0;
    cap = (sh_plen[e] > 32) ? 32 : sh_plen[e];
    c = 0;
    for (int b = 31; b >= 0; b--) begin
      if (key[b] != sh_addr[e][b]) break;
      c++;
    end
    return (c > cap) ? cap : c;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(int idx, logic [31:0] a, int pl, logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_addr = a; wr_plen = 6'(pl); wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    sh_addr[idx] = a; sh_plen[idx] = pl; sh_vld[idx] = v;
  endtask

  task automatic do_search(logic [31:0] k);
    @(negedge clk);
    srch_vld = 1'b1; srch_key = k;
    @(negedge clk);
    srch_vld = 1'b0;
  endtask

  task automatic check_lengths(logic [31:0] k, string tag);
    for (int e = 0; e < N; e++) begin
      check(tag, res_len[e*LW +: LW], model_len(k, e));
    end
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] last_hit;
    logic [N*LW-1:0] last_len;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_addr = '0; wr_plen = '0;
    wr_valid = 1'b0; srch_vld = 1'b0; srch_key = '0;
    for (int e = 0; e < N; e++) begin
      sh_addr[e] = '0; sh_plen[e] = 0; sh_vld[e] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 res_valid", res_valid, 0);
    check("R8 res_hit", res_hit, 0);
    check("R8 res_len", res_len, 0);
    rst_n = 1'b1;
    do_search(32'h00000000);
    check("R8 empty hit", res_hit, 0);
    check("R8 empty len", res_len, 0);

    // R10: fill slots in scrambled order
    do_write(7, 32'h80000000, 1, 1'b1);
    do_write(2, 32'h0A010200, 24, 1'b1);
    do_write(5, 32'hC0A80100, 40, 1'b1);  // R7: stored as 32
    do_write(0, 32'h0A000000, 8, 1'b1);
    do_write(3, 32'h00000000, 0, 1'b1);   // R4: default route
    do_write(4, 32'hC0A80144, 32, 1'b1);
    do_write(6, 32'hFFFFFFFF, 8, 1'b0);   // R5: not valid
    do_write(1, 32'h0A010000, 16, 1'b1);

    // Vector table: R2 lengths, R3/R10 candidate masks, R1 valid
    for (int v = 0; v < NV; v++) begin
      do_search(VEC[v][39:8]);
      check("R1 res_valid", res_valid, 1);
      check("R3 R10 hit mask", res_hit, VEC[v][7:0]);
      check_lengths(VEC[v][39:8], "R2 length");
    end

    // R7: clamped entry reaches 32 on an exact key
    do_search(32'hC0A80100);
    check("R7 clamped len", res_len[5*LW +: LW], 32);
    check("R7 clamped hit", res_hit[5], 1);

    // R4: default route on zero key
    do_search(32'h00000000);
    check("R4 default hit", res_hit[3], 1);
    check("R4 default len", res_len[3*LW +: LW], 0);
    // R5: invalid slot silent even on an all-ones key
    do_search(32'hFFFFFFFF);
    check("R5 invalid hit", res_hit[6], 0);
    check("R5 invalid len", res_len[6*LW +: LW], 0);

    // R9: outputs hold while idle, R1 valid drops
    last_hit = res_hit; last_len = res_len;
    @(negedge clk);
    check("R1 idle valid", res_valid, 0);
    check("R9 hold hit", res_hit, last_hit);
    check("R9 hold len", res_len, last_len);

    // R6: write and search in the same cycle on slot 6
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_addr = 32'h0A000000; wr_plen = 6'd8; wr_valid = 1'b1;
    srch_vld = 1'b1; srch_key = 32'h0A010203;
    @(negedge clk);
    wr_en = 1'b0; srch_vld = 1'b0;
    check("R6 same-cycle old hit", res_hit[6], 0);
    check("R6 same-cycle old len", res_len[6*LW +: LW], 0);
    sh_addr[6] = 32'h0A000000; sh_plen[6] = 8; sh_vld[6] = 1'b1;
    do_search(32'h0A010203);
    check("R6 next-cycle hit", res_hit[6], 1);
    check("R6 next-cycle len", res_len[6*LW +: LW], 8);

    // R6 R5: invalidate slot 4 then search right away
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd4; wr_addr = 32'hC0A80144; wr_plen = 6'd32; wr_valid = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; srch_vld = 1'b1; srch_key = 32'hC0A80144;
    @(negedge clk);
    srch_vld = 1'b0;
    check("R5 after invalidate hit", res_hit[4], 0);
    check("R5 after invalidate len", res_len[4*LW +: LW], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule